// File: doc/BRIEF.md
# Operand Address Former

This block turns an addressing-mode code and the operand bytes of an instruction into the 16-bit memory address that the instruction reads or writes. It targets a small processor with two 8-bit accumulators. That processor has a single flat 64K address space, shared by RAM, ROM and I/O. Each request gives the mode code, up to two operand bytes, the current index register and the program counter of the instruction. One clock later the block returns either a qualified address or a flag that the instruction needs no memory access.

Four modes produce an address:

- **Page-zero:** one byte selects a location in 0x0000 to 0x00FF.
- **Literal:** two bytes give the full address, high byte first.
- **Index-offset:** an unsigned byte is added to the index register.
- **Branch target:** a signed byte is added to the program counter plus two.

Both sums wrap modulo 65536. Immediate, inherent and register-operand instructions produce no address. The block does not fetch operands, decode instruction length or model memory.

Top module: `ea_former`

## Requirements
- R1: While `rst` is high at a clock edge, on the following cycle `ea` is 0x0000 and both `ea_ok` and `ea_none` are low.
- R2: A request with `mode` = 3 (page-zero) yields `ea` = {0x00, `opnd0`} with `ea_ok` high.
- R3: A request with `mode` = 4 (literal) yields `ea` = {`opnd0`, `opnd1`}, where `opnd0` is the high byte, with `ea_ok` high.
- R4: A request with `mode` = 5 (index-offset) yields `ea` = (`xreg` + zero-extended `opnd0`) mod 65536 with `ea_ok` high.
- R5: A request with `mode` = 6 (branch target) yields `ea` = (`pc` + 2 + sign-extended `opnd0`) mod 65536 with `ea_ok` high.
- R6: A request with `mode` = 0 (inherent), 1 (register), 2 (immediate) or 7 (unassigned) yields `ea_none` high, `ea_ok` low and `ea` = 0x0000.
- R7: Results appear on the clock edge after a request. In a cycle with `req` low, both flags are low on the next cycle and `ea` keeps its previous value.
- R8: `ea_ok` and `ea_none` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one per instruction |
| mode | input | 3 | Addressing-mode code |
| opnd0 | input | 8 | First operand byte |
| opnd1 | input | 8 | Second operand byte |
| xreg | input | 16 | Index register |
| pc | input | 16 | Program counter of the current instruction |
| ea | output | 16 | Registered effective address |
| ea_ok | output | 1 | `ea` holds a valid address |
| ea_none | output | 1 | The request needs no memory address |

## Verification
Every result is due exactly one cycle after the edge that captures its request, because a single register stage sits between the inputs and the outputs. The bench drives each stimulus just after a falling edge. It predicts the outcome with an arithmetic model that handles negative offsets and wrap-around explicitly. It then compares all three outputs at the next falling edge, half a cycle after the capturing edge, so the outputs are compared every cycle. The run includes idle cycles and resets mid-run, so the hold behaviour and the reset value are checked against the same one-cycle timing.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    AM_INH = 3'd0,
    AM_REG = 3'd1,
    AM_IMM = 3'd2,
    AM_PZ  = 3'd3,
    AM_LIT = 3'd4,
    AM_IDX = 3'd5,
    AM_BR  = 3'd6,
    AM_RSV = 3'd7
  } am_e;

  typedef struct packed {
    logic needs_mem;
    logic use_page0;
    logic use_lit;
    logic base_pc;
    logic sext;
  } am_ctl_t;

endpackage

// File: rtl/ea_mode_dec.sv
module ea_mode_dec
  import ea_pkg::*;
(
  input  logic [2:0] mode,
  output am_ctl_t    ctl
);
  always_comb begin
    ctl = '0;
    case (am_e'(mode))
      AM_PZ:  begin ctl.needs_mem = 1'b1; ctl.use_page0 = 1'b1; end
      AM_LIT: begin ctl.needs_mem = 1'b1; ctl.use_lit   = 1'b1; end
      AM_IDX: begin ctl.needs_mem = 1'b1; end
      AM_BR:  begin ctl.needs_mem = 1'b1; ctl.base_pc = 1'b1; ctl.sext = 1'b1; end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/ea_offset_ext.sv
module ea_offset_ext #(
  parameter int IW = 8,
  parameter int OW = 16
) (
  input  logic [IW-1:0] din,
  input  logic          sext,
  output logic [OW-1:0] dout
);
  localparam int PAD = OW - IW;
  generate
    if (PAD > 0) begin : g_pad
      logic fill;
      assign fill = sext & din[IW-1];
      assign dout = {{PAD{fill}}, din};
    end else begin : g_nopad
      assign dout = din[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  always_comb s = a + b;
endmodule

// File: rtl/ea_former.sv
module ea_former
  import ea_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 2 * DW,
  parameter int PC_BIAS  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] opnd0,
  input  logic [DW-1:0] opnd1,
  input  logic [AW-1:0] xreg,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] ea,
  output logic          ea_ok,
  output logic          ea_none
);
  localparam int          HI_W  = AW - DW;
  localparam logic [AW-1:0] BIAS = AW'(PC_BIAS);

  am_ctl_t       ctl;
  logic [AW-1:0] off_w;
  logic [AW-1:0] pc_next;
  logic [AW-1:0] base;
  logic [AW-1:0] sum;
  logic [AW-1:0] ea_d;

  ea_mode_dec u_dec (.mode(mode), .ctl(ctl));

  ea_offset_ext #(.IW(DW), .OW(AW)) u_ext (
    .din(opnd0), .sext(ctl.sext), .dout(off_w)
  );

  ea_adder #(.W(AW)) u_pcadd (.a(pc), .b(BIAS), .s(pc_next));

  always_comb base = ctl.base_pc ? pc_next : xreg;

  ea_adder #(.W(AW)) u_eadd (.a(base), .b(off_w), .s(sum));

  always_comb begin
    if (!ctl.needs_mem)      ea_d = '0;
    else if (ctl.use_page0)  ea_d = {{HI_W{1'b0}}, opnd0};
    else if (ctl.use_lit)    ea_d = {opnd0[HI_W-1:0], opnd1};
    else                     ea_d = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea      <= '0;
      ea_ok   <= 1'b0;
      ea_none <= 1'b0;
    end else if (req) begin
      ea      <= ea_d;
      ea_ok   <= ctl.needs_mem;
      ea_none <= ~ctl.needs_mem;
    end else begin
      ea_ok   <= 1'b0;
      ea_none <= 1'b0;
    end
  end
endmodule

// File: rtl/ea_former_chk.sv
module ea_former_chk (
  input logic        clk,
  input logic        rst,
  input logic        req,
  input logic [2:0]  mode,
  input logic [7:0]  opnd0,
  input logic [7:0]  opnd1,
  input logic [15:0] xreg,
  input logic [15:0] pc,
  input logic [15:0] ea,
  input logic        ea_ok,
  input logic        ea_none
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ea == 16'h0000 && !ea_ok && !ea_none));

  // R2
  page0_chk: assert property (@(posedge clk) disable iff (rst)
    (req && mode == 3'd3) |=> (ea_ok && ea[15:8] == 8'h00 && ea[7:0] == $past(opnd0)));

  // R3
  literal_chk: assert property (@(posedge clk) disable iff (rst)
    (req && mode == 3'd4) |=> (ea_ok && ea == {$past(opnd0), $past(opnd1)}));

  // R4
  index_chk: assert property (@(posedge clk) disable iff (rst)
    (req && mode == 3'd5) |=> (ea_ok && ea == 16'($past(xreg) + {8'h00, $past(opnd0)})));

  // R5
  branch_chk: assert property (@(posedge clk) disable iff (rst)
    (req && mode == 3'd6) |=>
      (ea_ok && ea == 16'($past(pc) + 16'd2 + {{8{$past(opnd0[7])}}, $past(opnd0)})));

  // R6
  no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req && (mode < 3'd3 || mode == 3'd7)) |=> (ea_none && !ea_ok && ea == 16'h0000));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!ea_ok && !ea_none && $stable(ea)));

  // R8
  flags_excl_chk: assert property (@(posedge clk) !(ea_ok && ea_none));
endmodule

bind ea_former ea_former_chk u_chk (
  .clk(clk), .rst(rst), .req(req), .mode(mode), .opnd0(opnd0), .opnd1(opnd1),
  .xreg(xreg), .pc(pc), .ea(ea), .ea_ok(ea_ok), .ea_none(ea_none)
);

// File: tb/sim_ea_former.sv
module sim_ea_former;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  opnd0 = 8'h00;
  logic [7:0]  opnd1 = 8'h00;
  logic [15:0] xreg = 16'h0000;
  logic [15:0] pc = 16'h0000;
  logic [15:0] ea;
  logic        ea_ok;
  logic        ea_none;

  int checks = 0;
  int fails  = 0;
  int exp_ea = 0;
  bit exp_ok = 1'b0;
  bit exp_none = 1'b0;
  string tag = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  ea_former u0 (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .opnd0(opnd0), .opnd1(opnd1),
    .xreg(xreg), .pc(pc), .ea(ea), .ea_ok(ea_ok), .ea_none(ea_none)
  );

  task automatic compare();
    checks++;
    if (ea !== exp_ea[15:0] || ea_ok !== exp_ok || ea_none !== exp_none) begin
      fails++;
      $display("FAIL %s: ea=%h ok=%b none=%b expected ea=%h ok=%b none=%b",
               tag, ea, ea_ok, ea_none, exp_ea[15:0], exp_ok, exp_none);
    end
    checks++;
    if (ea_ok && ea_none) begin
      fails++;
      $display("FAIL R8: ok=%b none=%b expected not both high", ea_ok, ea_none);
    end
  endtask

  task automatic cyc(input bit r, input bit q, input int m, input int b0,
                     input int b1, input int ix, input int p);
    int off;
    rst = r; req = q; mode = 3'(m); opnd0 = 8'(b0); opnd1 = 8'(b1);
    xreg = 16'(ix); pc = 16'(p);
    if (r) begin
      exp_ea = 0; exp_ok = 0; exp_none = 0; tag = "R1";
    end else if (!q) begin
      exp_ok = 0; exp_none = 0; tag = "R7";
    end else begin
      case (m)
        3: begin exp_ea = b0; tag = "R2"; end
        4: begin exp_ea = b0 * 256 + b1; tag = "R3"; end
        5: begin exp_ea = (ix + b0) % 65536; tag = "R4"; end
        6: begin
             off = (b0 >= 128) ? b0 - 256 : b0;
             exp_ea = ((p + 2 + off) % 65536 + 65536) % 65536;
             tag = "R5";
           end
        default: begin exp_ea = 0; tag = "R6"; end
      endcase
      exp_ok   = (m >= 3 && m <= 6);
      exp_none = !exp_ok;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0, 0);          // R1 reset state
    cyc(1, 1, 4, 8'hAB, 8'hCD, 0, 0);   // R1 request ignored in reset
    cyc(0, 1, 3, 8'hFF, 8'h12, 16'h1234, 16'h5678); // R2
    cyc(0, 1, 3, 8'h00, 8'h00, 0, 0);              // R2
    cyc(0, 1, 4, 8'h12, 8'h34, 0, 0);              // R3 high byte first
    cyc(0, 1, 4, 8'hFF, 8'hFF, 0, 0);              // R3
    cyc(0, 1, 5, 8'hFF, 0, 16'hFFFF, 0);           // R4 wrap
    cyc(0, 1, 5, 8'h80, 0, 16'h1000, 0);           // R4 zero-extension
    cyc(0, 1, 6, 8'h80, 0, 0, 16'h1000);           // R5 most negative
    cyc(0, 1, 6, 8'h7F, 0, 0, 16'hFFF0);           // R5 positive wrap
    cyc(0, 1, 6, 8'h00, 0, 0, 16'hFFFE);           // R5 wrap on plus two
    cyc(0, 1, 6, 8'hFE, 0, 0, 16'h0000);           // R5 lands on start
    cyc(0, 0, 4, 8'h55, 8'h66, 0, 0);              // R7 hold
    cyc(0, 0, 5, 8'h01, 0, 16'h2222, 0);           // R7 hold
    for (int m = 0; m < 8; m++) cyc(0, 1, m, 8'h9C, 8'h3A, 16'h4000, 16'h8000); // R6 and modes
    cyc(1, 0, 0, 0, 0, 0, 0);                      // R1 mid-run reset
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 97) == 0, ($urandom % 4) != 0, int'($urandom % 8),
          int'($urandom % 256), int'($urandom % 256),
          int'($urandom % 65536), int'($urandom % 65536));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule